// File: doc/BRIEF.md
# Per-Destination Segment Retry Tracker

This block follows the delivery of one message that has been cut into segments and sent to several destinations at once. Each segment and destination pair has its own small state machine. The pair counts failures and times out with its own watchdog. It asks for a retransmission of only that segment to only that destination. It gives up on the destination once the retry budget is spent. A message-level state machine combines the per-destination results into an overall status and raises a one-cycle completion pulse. When some destinations have failed, it offers a mask so that an application-level resend reaches only those destinations.

A transmitter reports each segment it puts on the wire to a destination (`sent_vld`). The receiving side returns status tagged with segment and destination (`rsp_vld`, `rsp_ok`). A free-running tick (`wd_tick`) advances the watchdogs. Retry requests appear on `retry_vld`/`retry_seg`/`retry_dest` and are taken as issued in the cycle they are shown. Each retry request uses a flat pair index equal to dest*N_SEG+seg, and the lowest index is shown first.

Pair states: PAIR_IDLE (nothing sent), PAIR_WAIT (awaiting status), PAIR_RETRY (retransmission requested), PAIR_ACKED, PAIR_DEAD. Pair transitions:
- IDLE to WAIT on a sent event.
- WAIT to ACKED on a success status.
- WAIT to RETRY on a failure status or a timeout, while retries remain.
- WAIT to DEAD on a failure status or a timeout once the budget is spent.
- RETRY to WAIT when the request is issued. This restarts the watchdog.
- IDLE, WAIT or RETRY to DEAD when another pair of the same destination has died.
- Any state to IDLE on message start, or on a resend aimed at the pair's destination.

Message states: MSG_IDLE, MSG_ACTIVE, MSG_FINAL. Message transitions:
- IDLE to ACTIVE on start.
- ACTIVE to ACTIVE on start, which restarts the message.
- ACTIVE to FINAL when every destination is done or failed.
- FINAL to ACTIVE on start.
- FINAL to ACTIVE on resend, provided at least one destination failed.

Top module: `seg_retry_tracker`

## Requirements
- R1: After reset, msg_status is 0 (idle), and retry_vld, done_pulse, dest_done, dest_failed and resend_mask are all zero.
- R2: A destination's bit in dest_done is set once a success status has been received for every segment sent to it.
- R3: A failure status for a pair awaiting a response raises retry_vld in the next cycle, naming exactly that segment and destination. When several pairs are pending, the lowest pair index dest*N_SEG+seg is shown first, one pair per cycle.
- R4: A pair is retried at most MAX_RETRY (default 3) times. The next failure marks its destination failed in dest_failed, and no retry is requested for it.
- R5: WD_LIMIT ticks of wd_tick with no status while a pair awaits a response count as a failure of that pair. Each retransmission restarts the count from zero.
- R6: A status for a pair that is not awaiting a response has no effect. This covers a late or duplicate status and a status for a pair of a failed destination.
- R7: msg_status encodes 1 while the message is active. It encodes 2 when every destination completed and 3 when at least one destination failed. With a single destination, that destination failing gives 3.
- R8: Destinations are resolved independently, so one can be failed while others are done.
- R9: done_pulse is high for exactly one cycle, the first cycle in which msg_status shows a final value (2 or 3).
- R10: In the final state resend_mask equals dest_failed, and it is zero in every other state. A resend re-opens only the failed destinations, while done destinations keep their done bit. A resend with no failed destination is ignored.
- R11: A start clears all pair state and all per-destination results, and puts msg_status at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_start | input | 1 | Begin a new message, clearing all state |
| msg_resend | input | 1 | Re-open the failed destinations after the final status |
| sent_vld | input | 1 | A segment was sent to a destination |
| sent_seg | input | SEG_W | Segment of the sent event |
| sent_dest | input | DEST_W | Destination of the sent event |
| rsp_vld | input | 1 | Status returned from a receiver |
| rsp_seg | input | SEG_W | Segment the status refers to |
| rsp_dest | input | DEST_W | Destination the status came from |
| rsp_ok | input | 1 | 1 for success, 0 for failure (including CRC mismatch) |
| wd_tick | input | 1 | Watchdog time base |
| retry_vld | output | 1 | Retransmission request, issued this cycle |
| retry_seg | output | SEG_W | Segment to retransmit |
| retry_dest | output | DEST_W | Destination to retransmit to |
| dest_done | output | N_DEST | Per-destination all-segments-acknowledged |
| dest_failed | output | N_DEST | Per-destination retry budget exhausted |
| resend_mask | output | N_DEST | Destinations an application resend would target |
| msg_status | output | 2 | 0 idle, 1 active, 2 all done, 3 some failed |
| done_pulse | output | 1 | One-cycle message completion pulse |

## Verification
On every cycle the assertions check several properties. A pair's retry count never passes the budget, and its watchdog stays below its limit while waiting. An acknowledged or dead pair stays so until cleared. Retries never target a destination already done, the resend mask never overlaps a done destination, and the completion pulse never lasts two cycles. Only the bench scenarios can show the rest. That covers the exact cycle and order in which retries appear, and that a fourth failure ends the retries. It also covers the watchdog really restarting on a retransmission, late status being dropped, a resend reaching only the failed destinations, and the single-destination failure giving a failed message.

// File: rtl/seg_retry_pkg.sv
package seg_retry_pkg;

    typedef enum logic [2:0] {
        PAIR_IDLE  = 3'd0,
        PAIR_WAIT  = 3'd1,
        PAIR_RETRY = 3'd2,
        PAIR_ACKED = 3'd3,
        PAIR_DEAD  = 3'd4
    } pair_state_e;

    typedef enum logic [1:0] {
        MSG_IDLE   = 2'd0,
        MSG_ACTIVE = 2'd1,
        MSG_FINAL  = 2'd2
    } msg_state_e;

    localparam logic [1:0] STAT_IDLE = 2'd0;
    localparam logic [1:0] STAT_BUSY = 2'd1;
    localparam logic [1:0] STAT_OK   = 2'd2;
    localparam logic [1:0] STAT_FAIL = 2'd3;

endpackage

// File: rtl/seg_pair_cell.sv
module seg_pair_cell
    import seg_retry_pkg::*;
#(
    parameter int MAX_RETRY = 3,
    parameter int WD_LIMIT  = 16,
    localparam int CNT_W = $clog2(MAX_RETRY + 1),
    localparam int WD_W  = $clog2(WD_LIMIT + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        rearm,
    input  logic        abandon,
    input  logic        active,
    input  logic        sent_hit,
    input  logic        rsp_hit,
    input  logic        rsp_ok,
    input  logic        wd_tick,
    input  logic        grant,
    output pair_state_e state_o,
    output logic        pending_o
);

    pair_state_e            st_q, st_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [WD_W-1:0]        wd_q, wd_d;
    logic                   fail_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PAIR_IDLE;
            cnt_q <= '0;
            wd_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            wd_q  <= wd_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        wd_d     = wd_q;
        fail_now = 1'b0;
        if (clear || rearm) begin
            st_d  = PAIR_IDLE;
            cnt_d = '0;
            wd_d  = '0;
        end else if (active) begin
            unique case (st_q)
                PAIR_IDLE: begin
                    if (abandon) begin
                        st_d = PAIR_DEAD;
                    end else if (sent_hit) begin
                        st_d = PAIR_WAIT;
                        wd_d = '0;
                    end
                end
                PAIR_WAIT: begin
                    if (abandon) begin
                        st_d = PAIR_DEAD;
                    end else if (rsp_hit && rsp_ok) begin
                        st_d = PAIR_ACKED;
                    end else if ((rsp_hit && !rsp_ok) ||
                                 (wd_tick && wd_q == WD_W'(WD_LIMIT - 1))) begin
                        fail_now = 1'b1;
                    end else if (wd_tick) begin
                        wd_d = wd_q + 1'b1;
                    end
                    if (fail_now) begin
                        if (cnt_q == CNT_W'(MAX_RETRY)) begin
                            st_d = PAIR_DEAD;
                        end else begin
                            st_d  = PAIR_RETRY;
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                PAIR_RETRY: begin
                    if (abandon) begin
                        st_d = PAIR_DEAD;
                    end else if (grant) begin
                        st_d = PAIR_WAIT;
                        wd_d = '0;
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    assign state_o   = st_q;
    assign pending_o = (st_q == PAIR_RETRY);

    AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_RETRY)); // R4
    AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PAIR_WAIT) |-> (wd_q < WD_W'(WD_LIMIT))); // R5
    AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PAIR_ACKED && !clear && !rearm) |=> (st_q == PAIR_ACKED)); // R6
    AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PAIR_DEAD && !clear && !rearm) |=> (st_q == PAIR_DEAD)); // R4
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (st_q == PAIR_RETRY)); // R3
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PAIR_ACKED && $past(st_q) != PAIR_ACKED) |-> $past(rsp_hit && rsp_ok)); // R2

endmodule

// File: rtl/retry_pick.sv
module retry_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/msg_ctrl_fsm.sv
module msg_ctrl_fsm
    import seg_retry_pkg::*;
#(
    parameter int N_DEST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              resend,
    input  logic              all_resolved,
    input  logic [N_DEST-1:0] dest_failed,
    output logic              active,
    output logic              clear,
    output logic [N_DEST-1:0] rearm,
    output logic [N_DEST-1:0] resend_mask,
    output logic [1:0]        msg_status,
    output logic              done_pulse
);

    msg_state_e state_q, state_d;
    logic       pulse_q;
    logic       resend_take;

    assign resend_take = resend && (state_q == MSG_FINAL) && (|dest_failed);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MSG_IDLE: begin
                if (start) state_d = MSG_ACTIVE;
            end
            MSG_ACTIVE: begin
                if (start)             state_d = MSG_ACTIVE;
                else if (all_resolved) state_d = MSG_FINAL;
            end
            MSG_FINAL: begin
                if (start || resend_take) state_d = MSG_ACTIVE;
            end
            default: state_d = MSG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MSG_IDLE;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= (state_q == MSG_ACTIVE) && !start && all_resolved;
        end
    end

    always_comb begin
        active      = (state_q == MSG_ACTIVE);
        clear       = start;
        rearm       = resend_take ? dest_failed : '0;
        resend_mask = '0;
        done_pulse  = pulse_q;
        unique case (state_q)
            MSG_IDLE:   msg_status = STAT_IDLE;
            MSG_ACTIVE: msg_status = STAT_BUSY;
            MSG_FINAL: begin
                msg_status  = (|dest_failed) ? STAT_FAIL : STAT_OK;
                resend_mask = dest_failed;
            end
            default:    msg_status = STAT_IDLE;
        endcase
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R9
    AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MSG_FINAL && !start && !(|dest_failed)) |=> (state_q == MSG_FINAL)); // R10
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (msg_status == STAT_BUSY)); // R11

endmodule

// File: rtl/seg_retry_tracker.sv
module seg_retry_tracker
    import seg_retry_pkg::*;
#(
    parameter int N_DEST    = 4,
    parameter int N_SEG     = 8,
    parameter int MAX_RETRY = 3,
    parameter int WD_LIMIT  = 16,
    localparam int SEG_W  = (N_SEG > 1) ? $clog2(N_SEG) : 1,
    localparam int DEST_W = (N_DEST > 1) ? $clog2(N_DEST) : 1,
    localparam int N_PAIR = N_DEST * N_SEG,
    localparam int PAIR_W = (N_PAIR > 1) ? $clog2(N_PAIR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_start,
    input  logic              msg_resend,
    input  logic              sent_vld,
    input  logic [SEG_W-1:0]  sent_seg,
    input  logic [DEST_W-1:0] sent_dest,
    input  logic              rsp_vld,
    input  logic [SEG_W-1:0]  rsp_seg,
    input  logic [DEST_W-1:0] rsp_dest,
    input  logic              rsp_ok,
    input  logic              wd_tick,
    output logic              retry_vld,
    output logic [SEG_W-1:0]  retry_seg,
    output logic [DEST_W-1:0] retry_dest,
    output logic [N_DEST-1:0] dest_done,
    output logic [N_DEST-1:0] dest_failed,
    output logic [N_DEST-1:0] resend_mask,
    output logic [1:0]        msg_status,
    output logic              done_pulse
);

    logic [N_DEST-1:0][N_SEG-1:0] pair_acked;
    logic [N_DEST-1:0][N_SEG-1:0] pair_dead;
    logic [N_PAIR-1:0]            pick_req;
    logic [N_PAIR-1:0]            pick_grant;
    logic [PAIR_W-1:0]            pick_idx;
    logic                         ctl_active;
    logic                         ctl_clear;
    logic [N_DEST-1:0]            ctl_rearm;
    logic                         all_resolved;

    for (genvar gd = 0; gd < N_DEST; gd++) begin : g_dest
        for (genvar gs = 0; gs < N_SEG; gs++) begin : g_seg
            localparam int IDX = gd * N_SEG + gs;
            logic        sent_hit;
            logic        rsp_hit;
            logic        pend;
            pair_state_e st;

            assign sent_hit = sent_vld && (sent_dest == DEST_W'(gd)) && (sent_seg == SEG_W'(gs));
            assign rsp_hit  = rsp_vld  && (rsp_dest  == DEST_W'(gd)) && (rsp_seg  == SEG_W'(gs));

            seg_pair_cell #(
                .MAX_RETRY (MAX_RETRY),
                .WD_LIMIT  (WD_LIMIT)
            ) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (ctl_clear),
                .rearm     (ctl_rearm[gd]),
                .abandon   (dest_failed[gd]),
                .active    (ctl_active),
                .sent_hit  (sent_hit),
                .rsp_hit   (rsp_hit),
                .rsp_ok    (rsp_ok),
                .wd_tick   (wd_tick),
                .grant     (pick_grant[IDX]),
                .state_o   (st),
                .pending_o (pend)
            );

            assign pair_acked[gd][gs] = (st == PAIR_ACKED);
            assign pair_dead[gd][gs]  = (st == PAIR_DEAD);
            assign pick_req[IDX]      = pend && !dest_failed[gd];
        end
        assign dest_done[gd]   = &pair_acked[gd];
        assign dest_failed[gd] = |pair_dead[gd];
    end

    assign all_resolved = &(dest_done | dest_failed);

    retry_pick #(.N(N_PAIR)) u_pick (
        .req   (pick_req),
        .grant (pick_grant),
        .any   (retry_vld),
        .idx   (pick_idx)
    );

    assign retry_dest = DEST_W'(32'(pick_idx) / N_SEG);
    assign retry_seg  = SEG_W'(32'(pick_idx) % N_SEG);

    msg_ctrl_fsm #(.N_DEST(N_DEST)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (msg_start),
        .resend       (msg_resend),
        .all_resolved (all_resolved),
        .dest_failed  (dest_failed),
        .active       (ctl_active),
        .clear        (ctl_clear),
        .rearm        (ctl_rearm),
        .resend_mask  (resend_mask),
        .msg_status   (msg_status),
        .done_pulse   (done_pulse)
    );

    AST_RETRY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_vld |-> !dest_done[retry_dest]); // R3
    AST_MASK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (resend_mask & dest_done) == '0); // R10
    AST_QUIET_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_status == STAT_OK || msg_status == STAT_FAIL) |-> !retry_vld); // R4

endmodule

// File: tb/seg_retry_tracker_bench.sv
`timescale 1ns/100ps
module seg_retry_tracker_bench;

    localparam int ND = 3;
    localparam int NS = 2;
    localparam int MR = 3;
    localparam int WL = 4;

    localparam logic [2:0] OP_NOP = 3'd0, OP_START = 3'd1, OP_SENT = 3'd2, OP_OK = 3'd3,
                           OP_BAD = 3'd4, OP_TICK = 3'd5, OP_RESEND = 3'd6;

    // layout: [22:19] req, [18:16] op, [15] seg, [14:13] dest, [12] rv, [11] rs,
    // [10:9] rd, [8:6] done, [5:3] failed, [2:1] status, [0] pulse
    function automatic logic [22:0] v(input int rq, input logic [2:0] op, input int s, input int d,
                                      input int rv, input int rs, input int rd,
                                      input logic [2:0] dm, input logic [2:0] fm,
                                      input int st, input int dp);
        return {4'(rq), op, 1'(s), 2'(d), 1'(rv), 1'(rs), 2'(rd), dm, fm, 2'(st), 1'(dp)};
    endfunction

    localparam int NV = 46;
    localparam logic [22:0] VEC [0:NV-1] = '{
        v(11, OP_START, 0,0, 0,0,0, 3'b000,3'b000, 1,0),  // R11
        v(2,  OP_SENT,  0,0, 0,0,0, 3'b000,3'b000, 1,0),  // R2
        v(2,  OP_SENT,  1,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(2,  OP_SENT,  0,1, 0,0,0, 3'b000,3'b000, 1,0),
        v(2,  OP_SENT,  1,1, 0,0,0, 3'b000,3'b000, 1,0),
        v(2,  OP_SENT,  0,2, 0,0,0, 3'b000,3'b000, 1,0),
        v(2,  OP_SENT,  1,2, 0,0,0, 3'b000,3'b000, 1,0),
        v(2,  OP_OK,    0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(2,  OP_OK,    1,0, 0,0,0, 3'b001,3'b000, 1,0),
        v(6,  OP_OK,    0,0, 0,0,0, 3'b001,3'b000, 1,0),  // R6 duplicate
        v(3,  OP_BAD,   0,1, 1,0,1, 3'b001,3'b000, 1,0),  // R3
        v(3,  OP_NOP,   0,0, 0,0,0, 3'b001,3'b000, 1,0),
        v(4,  OP_BAD,   0,1, 1,0,1, 3'b001,3'b000, 1,0),  // R4
        v(4,  OP_NOP,   0,0, 0,0,0, 3'b001,3'b000, 1,0),
        v(4,  OP_BAD,   0,1, 1,0,1, 3'b001,3'b000, 1,0),
        v(4,  OP_NOP,   0,0, 0,0,0, 3'b001,3'b000, 1,0),
        v(4,  OP_BAD,   0,1, 0,0,0, 3'b001,3'b010, 1,0),
        v(6,  OP_OK,    1,1, 0,0,0, 3'b001,3'b010, 1,0),  // R6 abandoned pair
        v(8,  OP_OK,    0,2, 0,0,0, 3'b001,3'b010, 1,0),  // R8
        v(8,  OP_OK,    1,2, 0,0,0, 3'b101,3'b010, 1,0),
        v(9,  OP_NOP,   0,0, 0,0,0, 3'b101,3'b010, 3,1),  // R9 and R7
        v(9,  OP_NOP,   0,0, 0,0,0, 3'b101,3'b010, 3,0),
        v(10, OP_RESEND,0,0, 0,0,0, 3'b101,3'b000, 1,0),  // R10
        v(10, OP_SENT,  0,1, 0,0,0, 3'b101,3'b000, 1,0),
        v(10, OP_SENT,  1,1, 0,0,0, 3'b101,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b101,3'b000, 1,0),  // R5
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b101,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b101,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 1,0,1, 3'b101,3'b000, 1,0),
        v(3,  OP_NOP,   0,0, 1,1,1, 3'b101,3'b000, 1,0),  // R3 order
        v(3,  OP_NOP,   0,0, 0,0,0, 3'b101,3'b000, 1,0),
        v(2,  OP_OK,    0,1, 0,0,0, 3'b101,3'b000, 1,0),
        v(2,  OP_OK,    1,1, 0,0,0, 3'b111,3'b000, 1,0),
        v(9,  OP_NOP,   0,0, 0,0,0, 3'b111,3'b000, 2,1),  // R7 ok
        v(10, OP_RESEND,0,0, 0,0,0, 3'b111,3'b000, 2,0),  // R10 ignored
        v(11, OP_START, 0,0, 0,0,0, 3'b000,3'b000, 1,0),  // R11
        v(5,  OP_SENT,  0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(3,  OP_BAD,   0,0, 1,0,0, 3'b000,3'b000, 1,0),
        v(5,  OP_NOP,   0,0, 0,0,0, 3'b000,3'b000, 1,0),  // R5 restart
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 0,0,0, 3'b000,3'b000, 1,0),
        v(5,  OP_TICK,  0,0, 1,0,0, 3'b000,3'b000, 1,0)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       msg_start = 0, msg_resend = 0, sent_vld = 0, rsp_vld = 0, rsp_ok = 0, wd_tick = 0;
    logic [0:0] sent_seg = 0, rsp_seg = 0;
    logic [1:0] sent_dest = 0, rsp_dest = 0;
    logic       retry_vld, done_pulse;
    logic [0:0] retry_seg;
    logic [1:0] retry_dest, msg_status;
    logic [2:0] dest_done, dest_failed, resend_mask;

    logic       s_start = 0, s_sent = 0, s_rsp = 0, s_ok = 0;
    logic       s_rv, s_dp;
    logic [0:0] s_rs, s_rd, s_dd, s_df, s_rm;
    logic [1:0] s_st;

    int checks = 0;
    int fails  = 0;

    seg_retry_tracker #(.N_DEST(ND), .N_SEG(NS), .MAX_RETRY(MR), .WD_LIMIT(WL)) u_seg_retry_tracker (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_resend(msg_resend),
        .sent_vld(sent_vld), .sent_seg(sent_seg), .sent_dest(sent_dest),
        .rsp_vld(rsp_vld), .rsp_seg(rsp_seg), .rsp_dest(rsp_dest), .rsp_ok(rsp_ok),
        .wd_tick(wd_tick), .retry_vld(retry_vld), .retry_seg(retry_seg), .retry_dest(retry_dest),
        .dest_done(dest_done), .dest_failed(dest_failed), .resend_mask(resend_mask),
        .msg_status(msg_status), .done_pulse(done_pulse)
    );

    seg_retry_tracker #(.N_DEST(1), .N_SEG(1), .MAX_RETRY(MR), .WD_LIMIT(WL)) u_single (
        .clk(clk), .rst_n(rst_n), .msg_start(s_start), .msg_resend(1'b0),
        .sent_vld(s_sent), .sent_seg(1'b0), .sent_dest(1'b0),
        .rsp_vld(s_rsp), .rsp_seg(1'b0), .rsp_dest(1'b0), .rsp_ok(s_ok),
        .wd_tick(1'b0), .retry_vld(s_rv), .retry_seg(s_rs), .retry_dest(s_rd),
        .dest_done(s_dd), .dest_failed(s_df), .resend_mask(s_rm),
        .msg_status(s_st), .done_pulse(s_dp)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic single_step(input logic st, input logic sn, input logic rp, input logic ok);
        @(negedge clk);
        s_start = st; s_sent = sn; s_rsp = rp; s_ok = ok;
        @(posedge clk); #1;
        @(negedge clk);
        s_start = 0; s_sent = 0; s_rsp = 0; s_ok = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] act, exp;
        logic [2:0]  em;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", {retry_vld, done_pulse, msg_status, dest_done, dest_failed, resend_mask, 3'b0},
              16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", {retry_vld, done_pulse, msg_status, dest_done, dest_failed, resend_mask, 3'b0},
              16'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            msg_start = 0; msg_resend = 0; sent_vld = 0; rsp_vld = 0; rsp_ok = 0; wd_tick = 0;
            sent_seg = VEC[i][15]; sent_dest = VEC[i][14:13];
            rsp_seg  = VEC[i][15]; rsp_dest  = VEC[i][14:13];
            case (VEC[i][18:16])
                OP_START:  msg_start = 1;
                OP_SENT:   sent_vld = 1;
                OP_OK:     begin rsp_vld = 1; rsp_ok = 1; end
                OP_BAD:    begin rsp_vld = 1; rsp_ok = 0; end
                OP_TICK:   wd_tick = 1;
                OP_RESEND: msg_resend = 1;
                default:   ;
            endcase
            @(posedge clk); #1;
            em  = (VEC[i][2:1] >= 2) ? VEC[i][5:3] : 3'b000;
            exp = {VEC[i][12], VEC[i][12] ? VEC[i][11] : 1'b0, VEC[i][12] ? VEC[i][10:9] : 2'b00,
                   VEC[i][8:6], VEC[i][5:3], em, VEC[i][2:1], VEC[i][0]};
            act = {retry_vld, retry_vld ? retry_seg : 1'b0, retry_vld ? retry_dest : 2'b00,
                   dest_done, dest_failed, resend_mask, msg_status, done_pulse};
            check($sformatf("R%0d vector %0d", VEC[i][22:19], i), act, exp);
        end
        @(negedge clk);
        msg_start = 0; msg_resend = 0; sent_vld = 0; rsp_vld = 0; wd_tick = 0;

        // R7: single destination, budget exhausted -> failed message
        single_step(1, 0, 0, 0);
        single_step(0, 1, 0, 0);
        for (int k = 0; k < MR; k++) begin
            @(negedge clk); s_rsp = 1; s_ok = 0;
            @(posedge clk); #1;
            check("R4 single retry", {15'b0, s_rv}, 16'h1);
            @(negedge clk); s_rsp = 0;
            @(posedge clk); #1;
        end
        @(negedge clk); s_rsp = 1; s_ok = 0;
        @(posedge clk); #1;
        check("R4 single no retry", {13'b0, s_rv, s_df, s_dd}, 16'b010);
        @(negedge clk); s_rsp = 0;
        @(posedge clk); #1;
        check("R7 single failed", {11'b0, s_st, s_rm, s_dp, 1'b0}, {11'b0, 2'd3, 1'b1, 1'b1, 1'b0});
        @(posedge clk); #1;
        check("R9 single pulse", {15'b0, s_dp}, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule